// File: doc/BRIEF.md
# SDRAM burst column address generator

This block sits in the command path of an SDRAM controller or device model. It turns a read or write command and its start column into the column address of every beat of the burst. A mode-load command writes a small mode register from the address and bank-select inputs. That register sets four things:

- the burst length: 1, 2, 4, 8 or the whole page;
- the beat ordering: sequential or interleaved;
- the CAS latency code;
- the operation mode: normal, or one in which reads burst and writes are always single.

The data path is outside the block, and so is the output delay for CAS latency. The block exports the accepted latency code so that a neighbour can apply that delay.

Each beat is shown on `col_o` together with `beat_valid_o`. The final beat of a finite burst also raises `last_beat_o`. The page size is set by the `COLS` parameter (256, 512 or 1024 columns), and the column address is the low `log2(COLS)` bits of `addr_i`. A mode load with a reserved code raises `mode_err_o` for one cycle and leaves the mode register as it was.

Top module: `sdram_burst_colgen`

## Requirements
- R1: `cmd_i` is encoded as follows: 3'b000 no-op, 3'b001 mode load, 3'b010 read, 3'b011 write, 3'b100 burst stop. A legal mode load takes its fields from `addr_i`. Bits [2:0] give the length: 000=1, 001=2, 010=4, 011=8, 111=page. Bit [3] gives the ordering: 0 sequential, 1 interleaved. Bits [6:4] give the latency: 010=2, 011=3. `cas_lat_o` shows the new latency from the cycle after the load.
- R2: A mode load is rejected in any of these cases: a reserved length code; a latency code other than 2 or 3; an operation field {bank_i, addr_i[11:7]} that is neither all zero nor only addr_i[9] set; or page length combined with interleaved ordering. A rejected load raises `mode_err_o` for exactly the next cycle and keeps the previous mode.
- R3: A read or write raises `beat_valid_o` in the cycle after the command, with `col_o` equal to the start column. One new beat follows on each later cycle.
- R4: In sequential order the low bits of the column count up from the start and wrap inside the aligned block of the burst length. The upper column bits are unchanged. For example, start 0x45 with length 8 gives 0x45,46,47,40,41,42,43,44.
- R5: In interleaved order the low bits of beat i are the start bits XOR i. For example, start 0x45 with length 8 gives 0x45,44,47,46,41,40,43,42.
- R6: A burst of length 1, 2, 4 or 8 produces exactly that many beats. `last_beat_o` is high only on the final beat, and `beat_valid_o` falls in the cycle after it unless a new command arrives.
- R7: A page burst is sequential over the whole column range. It wraps from COLS-1 to 0, never raises `last_beat_o`, and runs until it is stopped or restarted.
- R8: A burst stop ends a page burst, so `beat_valid_o` is low from the next cycle. During a finite burst a burst stop is ignored and the burst completes with its normal column sequence.
- R9: In single-write mode (mode load with only addr_i[9] set in the operation field), a write produces one beat with `last_beat_o` high. A read still uses the programmed length.
- R10: A read or write that arrives during a burst aborts that burst. The next cycle shows beat 0 of the new start column.
- R11: After reset `beat_valid_o`, `last_beat_o` and `mode_err_o` are low, and the mode is length 1, sequential, latency 2 and normal operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 3 | Command code (see R1) |
| addr_i | input | ADDR_W | Mode field on a mode load; start column in the low bits on a read or write |
| bank_i | input | BANK_W | Bank select; part of the operation field on a mode load |
| col_o | output | log2(COLS) | Column address of the current beat |
| beat_valid_o | output | 1 | A beat is present on `col_o` |
| last_beat_o | output | 1 | Final beat of a finite burst |
| cas_lat_o | output | 3 | Accepted latency code (2 or 3) |
| mode_err_o | output | 1 | One-cycle pulse after a rejected mode load |

## Verification
All results are registered, so each one is due one clock after the command edge that causes it. Beat 0 of a burst, a changed `cas_lat_o` and the `mode_err_o` pulse all appear then, and each later beat comes one clock after the one before it. The driver changes inputs on the falling edge and queues the result expected after the next rising edge. The monitor samples 1 ns after that rising edge and pops exactly one queued result per edge, so every comparison lines up with the cycle in which the output is due.

// File: rtl/sdram_colgen_pkg.sv
package sdram_colgen_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_MODE = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_STOP = 3'd4
  } cmd_e;

  localparam int CALC_W = 16;

  // Mask of the column bits that move inside one burst.
  function automatic logic [CALC_W-1:0] burst_mask(input logic [1:0] lg, input logic page);
    logic [CALC_W-1:0] one;
    one = {{(CALC_W-1){1'b0}}, 1'b1};
    return page ? {CALC_W{1'b1}} : ((one << lg) - one);
  endfunction

  // Column address of beat idx for a burst that starts at start.
  function automatic logic [CALC_W-1:0] beat_col(input logic [CALC_W-1:0] start,
                                                 input logic [CALC_W-1:0] idx,
                                                 input logic [1:0] lg,
                                                 input logic page,
                                                 input logic ilv);
    logic [CALC_W-1:0] m;
    m = burst_mask(lg, page);
    if (ilv) return start ^ (idx & m);
    return (start & ~m) | ((start + idx) & m);
  endfunction

endpackage

// File: rtl/sdram_mode_reg.sv
module sdram_mode_reg #(
  parameter int ADDR_W = 12,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic [1:0]        len_lg_o,
  output logic              page_o,
  output logic              ilv_o,
  output logic              single_wr_o,
  output logic [2:0]        cas_lat_o,
  output logic              err_o
);
  localparam int OP_W = BANK_W + ADDR_W - 7;
  localparam logic [OP_W-1:0] OP_NORMAL = '0;
  localparam logic [OP_W-1:0] OP_SGLWR  = OP_W'(4);

  logic [OP_W-1:0] op_field;
  logic [1:0] dec_lg;
  logic dec_page, len_ok, lat_ok, op_ok, combo_ok;
  logic load_ok, load_bad;

  assign op_field = {bank_i, addr_i[ADDR_W-1:7]};

  always_comb begin
    dec_lg   = 2'd0;
    dec_page = 1'b0;
    len_ok   = 1'b1;
    case (addr_i[2:0])
      3'b000: dec_lg = 2'd0;
      3'b001: dec_lg = 2'd1;
      3'b010: dec_lg = 2'd2;
      3'b011: dec_lg = 2'd3;
      3'b111: dec_page = 1'b1;
      default: len_ok = 1'b0;
    endcase
  end

  assign lat_ok   = (addr_i[6:4] == 3'd2) || (addr_i[6:4] == 3'd3);
  assign op_ok    = (op_field == OP_NORMAL) || (op_field == OP_SGLWR);
  assign combo_ok = !(dec_page && addr_i[3]);
  assign load_ok  = load_i && len_ok && lat_ok && op_ok && combo_ok;
  assign load_bad = load_i && !load_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_lg_o    <= 2'd0;
      page_o      <= 1'b0;
      ilv_o       <= 1'b0;
      single_wr_o <= 1'b0;
      cas_lat_o   <= 3'd2;
      err_o       <= 1'b0;
    end else begin
      err_o <= load_bad;
      if (load_ok) begin
        len_lg_o    <= dec_lg;
        page_o      <= dec_page;
        ilv_o       <= addr_i[3];
        single_wr_o <= (op_field == OP_SGLWR);
        cas_lat_o   <= addr_i[6:4];
      end
    end
  end

  assert_bad_keeps_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_bad |=> err_o && $stable({len_lg_o, page_o, ilv_o, single_wr_o, cas_lat_o}));
  assert_err_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_bad |=> !err_o);
  assert_lat_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_lat_o == 3'd2) || (cas_lat_o == 3'd3));
  assert_page_sequential_R7: assert property (@(posedge clk) disable iff (!rst_n)
    page_o |-> !ilv_o);

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sdram_colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             is_wr_i,
  input  logic             stop_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [1:0]       len_lg_i,
  input  logic             page_i,
  input  logic             ilv_i,
  input  logic             single_wr_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  logic             act_q, page_q, ilv_q;
  logic [1:0]       lg_q;
  logic [COL_W-1:0] start_q, idx_q, final_idx;
  logic             wr_single, stop_evt, at_last;
  logic [CALC_W-1:0] col_full;

  assign wr_single = start_i && is_wr_i && single_wr_i;
  assign final_idx = COL_W'(burst_mask(lg_q, 1'b0));
  assign at_last   = act_q && !page_q && (idx_q == final_idx);
  assign stop_evt  = stop_i && act_q && page_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      page_q  <= 1'b0;
      ilv_q   <= 1'b0;
      lg_q    <= 2'd0;
      start_q <= '0;
      idx_q   <= '0;
    end else if (start_i) begin
      act_q   <= 1'b1;
      start_q <= start_col_i;
      idx_q   <= '0;
      lg_q    <= wr_single ? 2'd0 : len_lg_i;
      page_q  <= wr_single ? 1'b0 : page_i;
      ilv_q   <= ilv_i;
    end else if (stop_evt) begin
      act_q <= 1'b0;
    end else if (act_q) begin
      if (at_last) act_q <= 1'b0;
      else         idx_q <= idx_q + 1'b1;
    end
  end

  assign col_full = beat_col(CALC_W'(start_q), CALC_W'(idx_q), lg_q, page_q, ilv_q);
  assign col_o    = col_full[COL_W-1:0];
  assign valid_o  = act_q;
  assign last_o   = at_last;

  assert_start_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> valid_o && (col_o == $past(start_col_i)));
  assert_single_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_single |=> valid_o && last_o);
  assert_last_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !start_i) |=> !valid_o);
  assert_continue_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !last_o && !start_i && !stop_evt) |=> valid_o);
  assert_stop_page_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && !start_i) |=> !valid_o);
  assert_last_has_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import sdram_colgen_pkg::*;
#(
  parameter int COLS   = 256,
  parameter int ADDR_W = 12,
  parameter int BANK_W = 2,
  localparam int COL_W = $clog2(COLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic [COL_W-1:0]  col_o,
  output logic              beat_valid_o,
  output logic              last_beat_o,
  output logic [2:0]        cas_lat_o,
  output logic              mode_err_o
);
  logic       load_evt, start_evt, wr_evt, stop_req;
  logic [1:0] len_lg;
  logic       page_md, ilv_md, sglwr_md;

  assign load_evt  = (cmd_i == CMD_MODE);
  assign wr_evt    = (cmd_i == CMD_WR);
  assign start_evt = (cmd_i == CMD_RD) || wr_evt;
  assign stop_req  = (cmd_i == CMD_STOP);

  sdram_mode_reg #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .load_i(load_evt), .addr_i(addr_i), .bank_i(bank_i),
    .len_lg_o(len_lg), .page_o(page_md), .ilv_o(ilv_md), .single_wr_o(sglwr_md),
    .cas_lat_o(cas_lat_o), .err_o(mode_err_o)
  );

  sdram_burst_seq #(.COL_W(COL_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_evt), .is_wr_i(wr_evt), .stop_i(stop_req),
    .start_col_i(addr_i[COL_W-1:0]), .len_lg_i(len_lg), .page_i(page_md),
    .ilv_i(ilv_md), .single_wr_i(sglwr_md),
    .col_o(col_o), .valid_o(beat_valid_o), .last_o(last_beat_o)
  );

  assert_mode_load_no_beat_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !beat_valid_o) |=> !beat_valid_o);
  assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && beat_valid_o) |=> beat_valid_o && (col_o == $past(addr_i[COL_W-1:0])));

endmodule

// File: tb/sdram_burst_colgen_bench.sv
module sdram_burst_colgen_bench;
  localparam int COLS = 256;
  localparam logic [2:0] C_NOP = 3'd0, C_MODE = 3'd1, C_RD = 3'd2, C_WR = 3'd3, C_STOP = 3'd4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] cmd = C_NOP;
  logic [11:0] addr = '0;
  logic [1:0] bank = '0;
  logic [7:0] col;
  logic valid, last, err;
  logic [2:0] lat;

  always #2.5 clk = ~clk;

  sdram_burst_colgen u_sdram_burst_colgen (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .addr_i(addr), .bank_i(bank),
    .col_o(col), .beat_valid_o(valid), .last_beat_o(last), .cas_lat_o(lat), .mode_err_o(err)
  );

  typedef struct { bit v; int c; bit l; bit e; int lat; } exp_t;
  exp_t q[$];
  string tq[$];
  int nvec = 0, nbad = 0;

  int m_len = 1, m_lat = 2;
  bit m_page = 0, m_ilv = 0, m_sw = 0;
  bit b_act = 0, b_page = 0, b_ilv = 0;
  int b_start = 0, b_idx = 0, b_len = 1;

  function automatic int ref_col();
    int base, off;
    if (b_page) return (b_start + b_idx) % COLS;
    off = b_start % b_len;
    base = b_start - off;
    if (b_ilv) return base + (off ^ b_idx);
    return base + ((off + b_idx) % b_len);
  endfunction

  task automatic step(input logic [2:0] c, input logic [11:0] a, input logic [1:0] b, input string tag);
    exp_t e;
    bit bad;
    int nl;
    bit np;
    logic [6:0] op;
    @(negedge clk);
    cmd = c; addr = a; bank = b;
    bad = 0; nl = 1; np = 0;
    if (c == C_MODE) begin
      case (a[2:0])
        3'b000: nl = 1;
        3'b001: nl = 2;
        3'b010: nl = 4;
        3'b011: nl = 8;
        3'b111: np = 1;
        default: bad = 1;
      endcase
      if (a[6:4] != 3'd2 && a[6:4] != 3'd3) bad = 1;
      op = {b, a[11:7]};
      if (op != 7'd0 && op != 7'b0000100) bad = 1;
      if (np && a[3]) bad = 1;
      if (!bad) begin
        m_len = nl; m_page = np; m_ilv = a[3]; m_lat = int'(a[6:4]); m_sw = (op != 7'd0);
      end
    end
    if (c == C_RD || c == C_WR) begin
      b_act = 1; b_start = int'(a) % COLS; b_idx = 0; b_ilv = m_ilv;
      if (c == C_WR && m_sw) begin b_len = 1; b_page = 0; end
      else begin b_len = m_len; b_page = m_page; end
    end else if (c == C_STOP && b_act && b_page) begin
      b_act = 0;
    end else if (b_act) begin
      if (!b_page && b_idx == b_len - 1) b_act = 0;
      else b_idx = b_page ? (b_idx + 1) % COLS : b_idx + 1;
    end
    e.v = b_act;
    e.c = b_act ? ref_col() : 0;
    e.l = b_act && !b_page && (b_idx == b_len - 1);
    e.e = bad;
    e.lat = m_lat;
    q.push_back(e);
    tq.push_back(tag);
    @(posedge clk);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(C_NOP, 12'h000, 2'd0, tag);
  endtask

  always @(posedge clk) begin
    exp_t e;
    string t;
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      t = tq.pop_front();
      nvec++;
      if (valid !== e.v || last !== e.l || err !== e.e || int'(lat) != e.lat ||
          (e.v && int'(col) != e.c)) begin
        nbad++;
        $display("FAIL %s: got v=%0d col=%0d last=%0d err=%0d lat=%0d, expected v=%0d col=%0d last=%0d err=%0d lat=%0d",
                 t, valid, col, last, err, lat, e.v, e.c, e.l, e.e, e.lat);
      end
    end
  end

  initial begin
    #(200000 * 5);
    nbad++;
    $display("FAIL watchdog: got hang, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    nvec++;
    if (valid !== 1'b0 || last !== 1'b0 || err !== 1'b0 || lat !== 3'd2) begin
      nbad++;
      $display("FAIL R11: got v=%0d last=%0d err=%0d lat=%0d, expected v=0 last=0 err=0 lat=2",
               valid, last, err, lat);
    end
    @(negedge clk);
    rst_n = 1'b1;
    // R11 default length 1
    step(C_RD, 12'h025, 2'd0, "R11");
    idle(2, "R11");
    // R1 R4 sequential length 8, latency 3
    step(C_MODE, 12'h033, 2'd0, "R1");
    step(C_RD, 12'h045, 2'd0, "R4");
    idle(9, "R4");
    // R5 interleaved length 8
    step(C_MODE, 12'h03B, 2'd0, "R5");
    step(C_RD, 12'h045, 2'd0, "R5");
    idle(9, "R5");
    // R6 R8 length 4 sequential, stop ignored mid burst
    step(C_MODE, 12'h032, 2'd0, "R6");
    step(C_RD, 12'h013, 2'd0, "R6");
    step(C_STOP, 12'h000, 2'd0, "R8");
    idle(4, "R6");
    // R6 length 2 interleaved
    step(C_MODE, 12'h029, 2'd0, "R6");
    step(C_WR, 12'h0A7, 2'd0, "R6");
    idle(3, "R6");
    // R2 rejected loads keep length 2 interleaved latency 2
    step(C_MODE, 12'h034, 2'd0, "R2");
    step(C_MODE, 12'h043, 2'd0, "R2");
    step(C_MODE, 12'h03F, 2'd0, "R2");
    step(C_MODE, 12'h033, 2'd1, "R2");
    step(C_MODE, 12'h433, 2'd0, "R2");
    step(C_RD, 12'h0A6, 2'd0, "R2");
    idle(3, "R2");
    // R7 R8 page burst wraps, then stop
    step(C_MODE, 12'h037, 2'd0, "R7");
    step(C_RD, 12'h0FD, 2'd0, "R7");
    idle(6, "R7");
    step(C_STOP, 12'h000, 2'd0, "R8");
    idle(2, "R8");
    // R9 single-write mode
    step(C_MODE, 12'h233, 2'd0, "R9");
    step(C_WR, 12'h007, 2'd0, "R9");
    idle(2, "R9");
    step(C_RD, 12'h007, 2'd0, "R9");
    idle(9, "R9");
    // R10 restart mid burst
    step(C_MODE, 12'h033, 2'd0, "R10");
    step(C_RD, 12'h010, 2'd0, "R10");
    idle(2, "R10");
    step(C_WR, 12'h02C, 2'd0, "R10");
    idle(9, "R10");
    // R10 page burst restarted by read
    step(C_MODE, 12'h037, 2'd0, "R10");
    step(C_WR, 12'h080, 2'd0, "R10");
    idle(2, "R10");
    step(C_RD, 12'h0C1, 2'd0, "R10");
    idle(2, "R10");
    step(C_STOP, 12'h000, 2'd0, "R8");
    idle(2, "R8");
    @(negedge clk);
    cmd = C_NOP;
    repeat (2) @(posedge clk);
    #2;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule